// File: doc/BRIEF.md
# Word-Streamed Transfer Buffer

This block is the local staging memory of a serial flash controller. It stores 512 bytes and has two sides. A host register port moves whole 32-bit words in and out through a single data register. The sequencer that drives the serial phases takes bytes out for transmission and puts received bytes back in.

Software first writes a control word. That word picks whether the host fills or drains the buffer, turns the automatic word step on or off, and loads the host word pointer. After that, each access to the data register reaches the word under the pointer, and the pointer steps forward on its own.

The sequencer keeps a byte pointer of its own. A begin strobe loads it from a start-address register, which software normally sets to zero. A transfer whose length is not a multiple of four bytes still takes one last full-word host access. In that word only the low-order bytes carry data.

Top module: `xfer_buf`

## Requirements
- R1: Storage is 128 words of 32 bits, packed little-endian. Byte address 4n+k sits in bits 8k+7:8k of word n.
- R2: A control write loads three fields. Bit 31 is the direction (1 = host fills, 0 = host drains), bit 30 is auto-step, and bits 7:0 are the word pointer, reduced modulo 128. A control read returns the same fields in the same positions, with every other bit at zero.
- R3: Each data-register access (read or write strobe) made while auto-step is 1 moves the word pointer forward by one. While auto-step is 0 the pointer stays where it is.
- R4: The word pointer steps from 127 to 0.
- R5: In fill direction, a data write stores the 32-bit word at the pointer. In drain direction, a data read presents the word at the pointer on the read-data output from the next clock edge, and that value is held until the next valid read.
- R6: An access against the direction leaves the stored contents and the read-data output unchanged: a write while draining, or a read while filling. The pointer still moves if auto-step is set.
- R7: A control write in the same cycle as a data access takes precedence. The access is dropped and the pointer takes the value just written.
- R8: A begin strobe loads the sequencer byte pointer from the 9-bit start-address register. A transmit or receive request in the same cycle is dropped, and no transmit byte is produced.
- R9: A transmit request outputs the byte at the sequencer pointer, with its valid flag, one cycle later. The pointer then moves forward by one byte and wraps from 511 to 0.
- R10: A received byte is stored at the sequencer pointer, and the pointer moves forward by one byte.
- R11: When the received byte count is not a multiple of four, the lanes of the last word that were not written keep their earlier contents. One extra full-word host read returns the meaningful bytes in its low-order lanes.
- R12: A host write and a received byte can hit the same word in the same cycle. The received byte then wins its own lane, and the host word fills the other three lanes.
- R13: After reset these are all zero: the control fields, the read data, the start address, the sequencer pointer and the transmit valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ctrl_wr | input | 1 | Write strobe for the control register |
| host_start_wr | input | 1 | Write strobe for the sequencer start-address register |
| host_data_wr | input | 1 | Write strobe for the data register |
| host_data_rd | input | 1 | Read strobe for the data register |
| host_wdata | input | 32 | Host write data shared by all host registers |
| host_ctrl_rdata | output | 32 | Control register readback |
| host_data_rdata | output | 32 | Word returned by the last valid data read |
| seq_begin | input | 1 | Load the sequencer pointer from the start address |
| seq_tx_req | input | 1 | Request the next byte for transmission |
| seq_tx_byte | output | 8 | Byte fetched for transmission |
| seq_tx_valid | output | 1 | seq_tx_byte holds a newly fetched byte |
| seq_rx_valid | input | 1 | A received byte is present |
| seq_rx_byte | input | 8 | Received byte |

## Verification
A host data write and a received byte from the sequencer can land on the same stored word in one cycle. The bench provokes this by pointing the host pointer and the sequencer byte pointer at the same word and asserting both strobes together. It then reads that word back, and the result must show the received byte in its lane and the host word in the other three. A control write is also issued in the same cycle as a data read, and the bench confirms two things: the read data does not change, and the pointer takes the newly written value.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;

    localparam int unsigned WORD_BYTES    = 4;
    localparam int unsigned LANE_W        = 2;
    localparam int unsigned CTRL_DIR_BIT  = 31;
    localparam int unsigned CTRL_STEP_BIT = 30;
    localparam int unsigned CTRL_PTR_W    = 8;

    typedef enum logic {
        DIR_DRAIN = 1'b0,
        DIR_FILL  = 1'b1
    } xdir_e;

    typedef struct packed {
        xdir_e                  dir;
        logic                   step;
        logic [CTRL_PTR_W-1:0]  ptr;
    } hctrl_t;

    function automatic hctrl_t ctrl_decode(input logic [31:0] w);
        hctrl_t c;
        c.dir  = xdir_e'(w[CTRL_DIR_BIT]);
        c.step = w[CTRL_STEP_BIT];
        c.ptr  = w[CTRL_PTR_W-1:0];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_encode(input hctrl_t c);
        logic [31:0] w;
        w                   = '0;
        w[CTRL_DIR_BIT]     = c.dir;
        w[CTRL_STEP_BIT]    = c.step;
        w[CTRL_PTR_W-1:0]   = c.ptr;
        return w;
    endfunction

endpackage

// File: rtl/xbuf_store.sv
module xbuf_store
    import xbuf_pkg::*;
#(
    parameter int unsigned WORDS  = 128,
    parameter int unsigned WIDX_W = 7
) (
    input  logic                     clk,
    input  logic                     h_we,
    input  logic [WIDX_W-1:0]        h_idx,
    input  logic [31:0]              h_wdata,
    output logic [31:0]              h_rword,
    input  logic                     s_we,
    input  logic [WIDX_W-1:0]        s_idx,
    input  logic [LANE_W-1:0]        s_lane,
    input  logic [7:0]               s_wbyte,
    output logic [7:0]               s_rbyte
);

    logic [WORD_BYTES-1:0][7:0] h_lanes;
    logic [7:0]                 s_lanes [WORD_BYTES];

    // One byte-wide bank per lane; the sequencer write is issued after the
    // host write so its byte takes the lane when both hit the same word.
    for (genvar L = 0; L < WORD_BYTES; L++) begin : g_lane
        logic [7:0] bank [WORDS];

        always_ff @(posedge clk) begin
            if (h_we) begin
                bank[h_idx] <= h_wdata[8*L +: 8];
            end
            if (s_we && (s_lane == LANE_W'(L))) begin
                bank[s_idx] <= s_wbyte;
            end
        end

        assign h_lanes[L] = bank[h_idx];
        assign s_lanes[L] = bank[s_idx];
    end

    assign h_rword = h_lanes;
    assign s_rbyte = s_lanes[s_lane];

endmodule

// File: rtl/xbuf_host_port.sv
module xbuf_host_port
    import xbuf_pkg::*;
#(
    parameter int unsigned WORDS  = 128,
    parameter int unsigned WIDX_W = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctrl_wr,
    input  logic                data_wr,
    input  logic                data_rd,
    input  logic [31:0]         wdata,
    output logic [31:0]         ctrl_rdata,
    output logic [31:0]         data_rdata,
    output logic                mem_we,
    output logic [WIDX_W-1:0]   mem_idx,
    input  logic [31:0]         mem_rword
);

    xdir_e              dir_q;
    logic               step_q;
    logic [WIDX_W-1:0]  ptr_q;
    logic [31:0]        rdata_q;
    hctrl_t             ctrl_in;
    hctrl_t             ctrl_view;
    logic               access;
    logic               rd_ok;
    logic [WIDX_W-1:0]  ptr_next;

    assign ctrl_in  = ctrl_decode(wdata);
    assign access   = (data_wr || data_rd) && !ctrl_wr;
    assign mem_we   = data_wr && !ctrl_wr && (dir_q == DIR_FILL);
    assign rd_ok    = data_rd && !ctrl_wr && (dir_q == DIR_DRAIN);
    assign mem_idx  = ptr_q;
    assign ptr_next = (ptr_q == WIDX_W'(WORDS - 1)) ? '0 : ptr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= DIR_DRAIN;
            step_q <= 1'b0;
            ptr_q  <= '0;
        end else if (ctrl_wr) begin
            dir_q  <= ctrl_in.dir;
            step_q <= ctrl_in.step;
            ptr_q  <= ctrl_in.ptr[WIDX_W-1:0];
        end else if (access && step_q) begin
            ptr_q  <= ptr_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (rd_ok) begin
            rdata_q <= mem_rword;
        end
    end

    always_comb begin
        ctrl_view      = '0;
        ctrl_view.dir  = dir_q;
        ctrl_view.step = step_q;
        ctrl_view.ptr  = CTRL_PTR_W'(ptr_q);
    end

    assign ctrl_rdata = ctrl_encode(ctrl_view);
    assign data_rdata = rdata_q;

endmodule

// File: rtl/xbuf_seq_port.sv
module xbuf_seq_port
    import xbuf_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 512,
    parameter int unsigned BADDR_W   = 9,
    parameter int unsigned WIDX_W    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_wr,
    input  logic [BADDR_W-1:0]  start_wdata,
    input  logic                begin_i,
    input  logic                tx_req,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    output logic [7:0]          tx_byte,
    output logic                tx_valid,
    output logic                mem_we,
    output logic [WIDX_W-1:0]   mem_idx,
    output logic [LANE_W-1:0]   mem_lane,
    output logic [7:0]          mem_wbyte,
    input  logic [7:0]          mem_rbyte,
    output logic [BADDR_W-1:0]  start_addr,
    output logic [BADDR_W-1:0]  byte_ptr
);

    logic [BADDR_W-1:0] start_q;
    logic [BADDR_W-1:0] bptr_q;
    logic [BADDR_W-1:0] bptr_next;
    logic               act;
    logic               tx_go;
    logic [7:0]         tx_q;
    logic               txv_q;

    assign tx_go     = tx_req && !begin_i;
    assign act       = (tx_req || rx_valid) && !begin_i;
    assign bptr_next = (bptr_q == BADDR_W'(BUF_BYTES - 1)) ? '0 : bptr_q + 1'b1;

    assign mem_we    = rx_valid && !begin_i;
    assign mem_idx   = bptr_q[BADDR_W-1:LANE_W];
    assign mem_lane  = bptr_q[LANE_W-1:0];
    assign mem_wbyte = rx_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (start_wr) begin
            start_q <= start_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bptr_q <= '0;
        end else if (begin_i) begin
            bptr_q <= start_q;
        end else if (act) begin
            bptr_q <= bptr_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            txv_q <= 1'b0;
        end else begin
            txv_q <= tx_go;
            if (tx_go) begin
                tx_q <= mem_rbyte;
            end
        end
    end

    assign tx_byte    = tx_q;
    assign tx_valid   = txv_q;
    assign start_addr = start_q;
    assign byte_ptr   = bptr_q;

endmodule

// File: rtl/xfer_buf.sv
module xfer_buf
    import xbuf_pkg::*;
#(
    parameter int unsigned BUF_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_ctrl_wr,
    input  logic        host_start_wr,
    input  logic        host_data_wr,
    input  logic        host_data_rd,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_ctrl_rdata,
    output logic [31:0] host_data_rdata,
    input  logic        seq_begin,
    input  logic        seq_tx_req,
    output logic [7:0]  seq_tx_byte,
    output logic        seq_tx_valid,
    input  logic        seq_rx_valid,
    input  logic [7:0]  seq_rx_byte
);

    localparam int unsigned WORDS   = BUF_BYTES / WORD_BYTES;
    localparam int unsigned WIDX_W  = $clog2(WORDS);
    localparam int unsigned BADDR_W = $clog2(BUF_BYTES);

    logic               h_we;
    logic [WIDX_W-1:0]  h_idx;
    logic [31:0]        h_rword;
    logic               s_we;
    logic [WIDX_W-1:0]  s_idx;
    logic [LANE_W-1:0]  s_lane;
    logic [7:0]         s_wbyte;
    logic [7:0]         s_rbyte;
    logic [BADDR_W-1:0] seq_start;
    logic [BADDR_W-1:0] seq_bptr;

    xbuf_host_port #(.WORDS(WORDS), .WIDX_W(WIDX_W)) u_host (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (host_ctrl_wr),
        .data_wr    (host_data_wr),
        .data_rd    (host_data_rd),
        .wdata      (host_wdata),
        .ctrl_rdata (host_ctrl_rdata),
        .data_rdata (host_data_rdata),
        .mem_we     (h_we),
        .mem_idx    (h_idx),
        .mem_rword  (h_rword)
    );

    xbuf_seq_port #(.BUF_BYTES(BUF_BYTES), .BADDR_W(BADDR_W), .WIDX_W(WIDX_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_wr    (host_start_wr),
        .start_wdata (host_wdata[BADDR_W-1:0]),
        .begin_i     (seq_begin),
        .tx_req      (seq_tx_req),
        .rx_valid    (seq_rx_valid),
        .rx_byte     (seq_rx_byte),
        .tx_byte     (seq_tx_byte),
        .tx_valid    (seq_tx_valid),
        .mem_we      (s_we),
        .mem_idx     (s_idx),
        .mem_lane    (s_lane),
        .mem_wbyte   (s_wbyte),
        .mem_rbyte   (s_rbyte),
        .start_addr  (seq_start),
        .byte_ptr    (seq_bptr)
    );

    xbuf_store #(.WORDS(WORDS), .WIDX_W(WIDX_W)) u_store (
        .clk     (clk),
        .h_we    (h_we),
        .h_idx   (h_idx),
        .h_wdata (host_wdata),
        .h_rword (h_rword),
        .s_we    (s_we),
        .s_idx   (s_idx),
        .s_lane  (s_lane),
        .s_wbyte (s_wbyte),
        .s_rbyte (s_rbyte)
    );

endmodule

// File: rtl/xfer_buf_chk.sv
module xfer_buf_chk #(
    parameter int unsigned BUF_BYTES = 512
) (
    input logic        clk,
    input logic        rst,
    input logic        host_ctrl_wr,
    input logic        host_data_wr,
    input logic        host_data_rd,
    input logic [31:0] host_wdata,
    input logic [31:0] host_ctrl_rdata,
    input logic [31:0] host_data_rdata,
    input logic        seq_begin,
    input logic        seq_tx_req,
    input logic        seq_tx_valid,
    input logic        seq_rx_valid,
    input logic [8:0]  seq_start,
    input logic [8:0]  seq_bptr
);

    localparam int unsigned WORDS = BUF_BYTES / 4;

    logic acc;
    logic [7:0]  ptr_f;
    logic [31:0] ctrl_mask;
    assign acc       = (host_data_wr || host_data_rd) && !host_ctrl_wr;
    assign ptr_f     = host_ctrl_rdata[7:0];
    assign ctrl_mask = {host_wdata[31:30], 22'b0, 8'(host_wdata[7:0] % WORDS)};

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (acc && host_ctrl_rdata[30]) |=>
        (ptr_f == (($past(ptr_f) == 8'(WORDS - 1)) ? 8'd0 : $past(ptr_f) + 8'd1))); // R3 R4

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!host_ctrl_wr && !(acc && host_ctrl_rdata[30])) |=> $stable(host_ctrl_rdata)); // R3

    AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
        host_ctrl_wr |=> (host_ctrl_rdata == $past(ctrl_mask))); // R2

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(host_data_rd && !host_ctrl_wr && !host_ctrl_rdata[31]) |=> $stable(host_data_rdata)); // R6

    AST_TX_VALID: assert property (@(posedge clk) disable iff (rst)
        (seq_tx_req && !seq_begin) |=> seq_tx_valid); // R9

    AST_TX_DROP: assert property (@(posedge clk) disable iff (rst)
        (seq_begin || !seq_tx_req) |=> !seq_tx_valid); // R8

    AST_BEGIN_LOAD: assert property (@(posedge clk) disable iff (rst)
        seq_begin |=> (seq_bptr == $past(seq_start))); // R8

    AST_BPTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!seq_begin && (seq_tx_req || seq_rx_valid)) |=>
        (seq_bptr == (($past(seq_bptr) == 9'(BUF_BYTES - 1)) ? 9'd0 : $past(seq_bptr) + 9'd1))); // R9 R10

endmodule

bind xfer_buf xfer_buf_chk #(.BUF_BYTES(BUF_BYTES)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .host_ctrl_wr    (host_ctrl_wr),
    .host_data_wr    (host_data_wr),
    .host_data_rd    (host_data_rd),
    .host_wdata      (host_wdata),
    .host_ctrl_rdata (host_ctrl_rdata),
    .host_data_rdata (host_data_rdata),
    .seq_begin       (seq_begin),
    .seq_tx_req      (seq_tx_req),
    .seq_tx_valid    (seq_tx_valid),
    .seq_rx_valid    (seq_rx_valid),
    .seq_start       (seq_start),
    .seq_bptr        (seq_bptr)
);

// File: tb/xfer_buf_tb.sv
`timescale 1ns/1ps
module xfer_buf_tb;

    localparam int NB    = 512;
    localparam int WORDS = NB / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_ctrl_wr, host_start_wr, host_data_wr, host_data_rd;
    logic [31:0] host_wdata;
    logic [31:0] host_ctrl_rdata, host_data_rdata;
    logic        seq_begin, seq_tx_req, seq_tx_valid, seq_rx_valid;
    logic [7:0]  seq_tx_byte, seq_rx_byte;

    always #2.5 clk = ~clk;

    xfer_buf #(.BUF_BYTES(NB)) u_dut (
        .clk(clk), .rst(rst),
        .host_ctrl_wr(host_ctrl_wr), .host_start_wr(host_start_wr),
        .host_data_wr(host_data_wr), .host_data_rd(host_data_rd),
        .host_wdata(host_wdata), .host_ctrl_rdata(host_ctrl_rdata),
        .host_data_rdata(host_data_rdata), .seq_begin(seq_begin),
        .seq_tx_req(seq_tx_req), .seq_tx_byte(seq_tx_byte),
        .seq_tx_valid(seq_tx_valid), .seq_rx_valid(seq_rx_valid),
        .seq_rx_byte(seq_rx_byte)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model built from the requirements
    logic [31:0] mdl [WORDS];
    bit          m_dir, m_step;
    int          m_ptr, m_sptr, m_start;
    logic [31:0] m_rd;
    logic [31:0] hq [$];
    logic [7:0]  tq [$];
    string       hq_req [$];
    logic        hrd_d;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] getb(int a);
        logic [31:0] w;
        w = mdl[a / 4];
        return w[8 * (a % 4) +: 8];
    endfunction

    function automatic void setb(int a, logic [7:0] b);
        mdl[a / 4][8 * (a % 4) +: 8] = b;
    endfunction

    function automatic void adv();
        if (m_step) m_ptr = (m_ptr + 1) % WORDS;
    endfunction

    task automatic idle();
        host_ctrl_wr = 0; host_start_wr = 0; host_data_wr = 0; host_data_rd = 0;
        host_wdata = '0; seq_begin = 0; seq_tx_req = 0; seq_rx_valid = 0; seq_rx_byte = '0;
    endtask

    task automatic chk_ctrl(string req);
        chk(req, host_ctrl_rdata, {m_dir, m_step, 22'b0, 8'(m_ptr)});
    endtask

    task automatic h_ctrl(bit d, bit s, int p);
        host_ctrl_wr = 1; host_wdata = {d, s, 22'b0, 8'(p)};
        @(negedge clk); idle();
        m_dir = d; m_step = s; m_ptr = p % WORDS;
    endtask

    task automatic h_wr(logic [31:0] w);
        host_data_wr = 1; host_wdata = w;
        @(negedge clk); idle();
        if (m_dir) mdl[m_ptr] = w;
        adv();
    endtask

    task automatic h_rd(string req);
        if (!m_dir) m_rd = mdl[m_ptr];
        hq.push_back(m_rd); hq_req.push_back(req);
        host_data_rd = 1;
        @(negedge clk); idle();
        adv();
    endtask

    task automatic s_start(int a);
        host_start_wr = 1; host_wdata = 32'(a);
        @(negedge clk); idle();
        m_start = a;
    endtask

    task automatic s_begin();
        seq_begin = 1;
        @(negedge clk); idle();
        m_sptr = m_start;
    endtask

    task automatic s_tx();
        tq.push_back(getb(m_sptr));
        seq_tx_req = 1;
        @(negedge clk); idle();
        m_sptr = (m_sptr + 1) % NB;
    endtask

    task automatic s_rx(logic [7:0] b);
        seq_rx_valid = 1; seq_rx_byte = b;
        @(negedge clk); idle();
        setb(m_sptr, b);
        m_sptr = (m_sptr + 1) % NB;
    endtask

    // monitors: compare outputs against the scoreboard queues
    always @(posedge clk) hrd_d <= host_data_rd && !rst;

    always @(negedge clk) begin
        if (!rst && hrd_d) begin
            if (hq.size() == 0) begin
                chk("R5 unexpected read", host_data_rdata, 32'hxxxxxxxx);
            end else begin
                chk(hq_req.pop_front(), host_data_rdata, hq.pop_front());
            end
        end
        if (!rst && seq_tx_valid) begin
            if (tq.size() == 0) begin
                chk("R8 unexpected tx byte", {24'b0, seq_tx_byte}, 32'hffffffff);
            end else begin
                chk("R9 R1 tx byte", {24'b0, seq_tx_byte}, {24'b0, tq.pop_front()});
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL R13: watchdog expired, actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        m_dir = 0; m_step = 0; m_ptr = 0; m_sptr = 0; m_start = 0; m_rd = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R13 ctrl after reset", host_ctrl_rdata, 32'h0);
        chk("R13 rdata after reset", host_data_rdata, 32'h0);
        chk("R13 tx valid after reset", {31'b0, seq_tx_valid}, 32'h0);

        // R2 R5 fill five words with auto-step
        h_ctrl(1, 1, 0);
        chk("R2 ctrl readback", host_ctrl_rdata, 32'hC000_0000);
        for (int i = 0; i < 5; i++) h_wr(32'h1000_0000 + 32'(i * 32'h0102_0304));
        chk_ctrl("R3 pointer after five writes");

        // R5 drain them back
        h_ctrl(0, 1, 0);
        for (int i = 0; i < 5; i++) h_rd("R5 drain word");
        chk_ctrl("R3 pointer after five reads");

        // R3 no auto-step: pointer holds
        h_ctrl(0, 0, 2);
        h_rd("R3 hold read a");
        h_rd("R3 hold read b");
        chk_ctrl("R3 pointer held");

        // R2 pointer modulo
        h_ctrl(0, 0, 130);
        chk("R2 pointer modulo", host_ctrl_rdata, 32'h0000_0002);

        // R4 wrap
        h_ctrl(1, 1, 127);
        h_wr(32'hA5A5_0127);
        h_wr(32'h5A5A_0000);
        chk_ctrl("R4 pointer wrapped");
        h_ctrl(0, 1, 127);
        h_rd("R4 last word");
        h_rd("R4 word after wrap");

        // R6 mismatched direction
        h_ctrl(0, 1, 3);
        h_wr(32'hDEAD_BEEF);
        chk_ctrl("R6 pointer moved on ignored write");
        h_ctrl(0, 0, 3);
        h_rd("R6 word untouched by ignored write");
        h_ctrl(1, 1, 0);
        h_rd("R6 rdata unchanged on ignored read");
        chk_ctrl("R6 pointer moved on ignored read");

        // R7 control write wins over same-cycle read
        host_ctrl_wr = 1; host_data_rd = 1; host_wdata = {1'b0, 1'b1, 22'b0, 8'd9};
        hq.push_back(m_rd); hq_req.push_back("R7 read dropped");
        @(negedge clk); idle();
        m_dir = 0; m_step = 1; m_ptr = 9;
        chk_ctrl("R7 pointer from control write");

        // R1 R9 transmit eight bytes from address zero
        s_start(0);
        s_begin();
        for (int i = 0; i < 8; i++) s_tx();

        // R10 R11 receive six bytes at address 9
        s_start(9);
        s_begin();
        for (int i = 0; i < 6; i++) s_rx(8'h11 * 8'(i + 1));
        h_ctrl(0, 1, 2);
        h_rd("R10 received word");
        h_rd("R11 partial final word");

        // R9 byte pointer wrap
        s_start(510);
        s_begin();
        for (int i = 0; i < 3; i++) s_tx();

        // R8 begin drops a same-cycle transmit
        s_start(4);
        seq_begin = 1; seq_tx_req = 1;
        @(negedge clk); idle();
        m_sptr = m_start;
        s_tx();

        // R12 same-word collision
        s_start(20);
        s_begin();
        h_ctrl(1, 1, 5);
        host_data_wr = 1; host_wdata = 32'hAABB_CCDD; seq_rx_valid = 1; seq_rx_byte = 8'h5A;
        @(negedge clk); idle();
        mdl[m_ptr] = 32'hAABB_CCDD; adv();
        setb(m_sptr, 8'h5A); m_sptr = m_sptr + 1;
        chk("R12 model", mdl[5], 32'hAABB_CC5A);
        h_ctrl(0, 0, 5);
        h_rd("R12 collision word");

        repeat (4) @(negedge clk);
        chk("R5 read queue drained", 32'(hq.size()), 32'd0);
        chk("R9 tx queue drained", 32'(tq.size()), 32'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule